// File: doc/BRIEF.md
# Multi-Rail Undervoltage and Thermal Fault Monitor

This block gathers the digital results of several per-rail undervoltage comparators and two die-temperature comparators, and turns them into one fault indication plus a sticky thermal shutdown command. The comparators themselves sit in the analog domain. Each one reports a single bit per rail that is high while that rail sits below roughly 69% of its set point. The monitor only reports undervoltage; it never switches a rail off because of one. Other logic decides what to do with the fault pin, for example pulling the soft-start node low.

A rail's undervoltage bit counts only while two conditions hold: the rail is enabled, and the soft-start sequencer has raised the monitor-enable input, which it does once ramp-up is complete. A qualified bit must stay high for a programmable number of clock cycles before it is reported. This is the reporting delay, a few microseconds in a typical system. The two temperature inputs behave differently:
- The warning level raises the fault output directly, and operation carries on.
- The shutdown level sets a latch that commands every rail off. Only a bias-supply power-on reset clears that latch.

While the shutdown request input is active, the fault output is held low.

Top module: `uv_fault_monitor`

## Requirements
- R1: While `por_n` is low, `fault` and `therm_off` are both 0.
- R2: If the condition `uv_flag[i] & rail_en[i] & mon_en` is sampled high on `DLY_CYC` consecutive rising edges, `fault` reads 1 after the following edge. A shorter run does not set `fault`, even if it is restarted after a gap. The bench uses `DLY_CYC` = 4.
- R3: When `rail_en[i]` is 0, `uv_flag[i]` has no effect on `fault`.
- R4: When `mon_en` is 0, no `uv_flag` bit has any effect on `fault`.
- R5: Suppose the qualified condition of a reported rail is first sampled low on edge k, and no other fault source is active. Then `fault` reads 0 after edge k+1.
- R6: When `ot_warn` is sampled high on an edge, `fault` reads 1 after that edge. When it is sampled low again, and no other source is active, `fault` reads 0 after that edge. `ot_warn` never changes `therm_off`.
- R7: When `ot_shdn` is sampled high on an edge, `therm_off` and `fault` read 1 after that edge. `therm_off` then stays 1 until `por_n` goes low, whatever the other inputs do.
- R8: When `shdn_req` is sampled high on an edge, `fault` reads 0 after that edge, whatever the active sources. `therm_off` is unchanged. After `shdn_req` is released, `fault` follows the active sources again from the next edge.
- R9: Undervoltage never sets `therm_off`.
- R10: Each rail keeps its own run count. Runs on different rails do not add together, and `fault` stays 1 while any rail is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| por_n | input | 1 | Bias-supply power-on reset, active low, asynchronous |
| uv_flag | input | N_RAILS | Per-rail undervoltage comparator results, 1 = below threshold |
| rail_en | input | N_RAILS | Per-rail enable, 1 = rail is monitored |
| mon_en | input | 1 | Monitor enable from the soft-start sequencer |
| shdn_req | input | 1 | Shutdown request, forces `fault` low |
| ot_warn | input | 1 | Die temperature above the warning level |
| ot_shdn | input | 1 | Die temperature above the shutdown level |
| fault | output | 1 | Combined fault report |
| therm_off | output | 1 | Latched thermal shutdown command for all rails |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `por_n` is held low long enough to settle every register. They also assume that the delay parameter is at least 2, so that a run has a definite start and end. The stimulus changes inputs only on the falling edge. It keeps `por_n` low across several edges at each reset, and it builds every undervoltage run from whole clock cycles. The sweep covers every rail, every combination of rail enable and monitor enable, and every run length from one cycle up to two cycles past the delay.

// File: rtl/ufm_pkg.sv
package ufm_pkg;
  typedef struct packed {
    logic uv;    // at least one rail reported undervoltage
    logic warn;  // warning-level overtemperature
    logic hot;   // shutdown-level overtemperature, live or latched
  } fault_src_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ufm_rail_qual.sv
module ufm_rail_qual #(
  parameter int unsigned DLY_CYC = 500
) (
  input  logic clk,
  input  logic por_n,
  input  logic uv_raw,
  input  logic rail_en,
  input  logic mon_en,
  output logic uv_q
);
  localparam int unsigned CW = ufm_pkg::cnt_width(DLY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYC - 1);

  logic [CW-1:0] run_cnt;
  logic          qual;

  assign qual = uv_raw & rail_en & mon_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_cnt <= '0;
      uv_q    <= 1'b0;
    end else if (!qual) begin
      run_cnt <= '0;
      uv_q    <= 1'b0;
    end else if (run_cnt == LAST) begin
      uv_q    <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ufm_therm_latch.sv
module ufm_therm_latch (
  input  logic clk,
  input  logic por_n,
  input  logic ot_shdn,
  output logic therm_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) therm_q <= 1'b0;
    else        therm_q <= therm_q | ot_shdn;
  end
endmodule

// File: rtl/ufm_fault_merge.sv
module ufm_fault_merge
  import ufm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       shdn_req,
  input  fault_src_t src,
  output logic       fault_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) fault_q <= 1'b0;
    else        fault_q <= !shdn_req && (src.uv || src.warn || src.hot);
  end
endmodule

// File: rtl/uv_fault_monitor.sv
module uv_fault_monitor
  import ufm_pkg::*;
#(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned DLY_CYC = 500
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_RAILS-1:0] uv_flag,
  input  logic [N_RAILS-1:0] rail_en,
  input  logic               mon_en,
  input  logic               shdn_req,
  input  logic               ot_warn,
  input  logic               ot_shdn,
  output logic               fault,
  output logic               therm_off
);
  logic [N_RAILS-1:0] rail_uv;
  logic               therm_q;
  fault_src_t         src;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    ufm_rail_qual #(.DLY_CYC(DLY_CYC)) u_qual (
      .clk     (clk),
      .por_n   (por_n),
      .uv_raw  (uv_flag[g]),
      .rail_en (rail_en[g]),
      .mon_en  (mon_en),
      .uv_q    (rail_uv[g])
    );
  end

  ufm_therm_latch u_therm (
    .clk     (clk),
    .por_n   (por_n),
    .ot_shdn (ot_shdn),
    .therm_q (therm_q)
  );

  always_comb begin
    src.uv   = |rail_uv;
    src.warn = ot_warn;
    src.hot  = ot_shdn | therm_q;
  end

  ufm_fault_merge u_merge (
    .clk      (clk),
    .por_n    (por_n),
    .shdn_req (shdn_req),
    .src      (src),
    .fault_q  (fault)
  );

  assign therm_off = therm_q;
endmodule

// File: rtl/ufm_checker.sv
module ufm_checker #(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned DLY_CYC = 500
) (
  input logic               clk,
  input logic               por_n,
  input logic [N_RAILS-1:0] uv_flag,
  input logic [N_RAILS-1:0] rail_en,
  input logic               mon_en,
  input logic               shdn_req,
  input logic               ot_warn,
  input logic               ot_shdn,
  input logic               fault,
  input logic               therm_off
);
  localparam int unsigned CW = ufm_pkg::cnt_width(DLY_CYC);
  localparam logic [CW-1:0] FULL = CW'(DLY_CYC);

  logic [N_RAILS-1:0] ripe;
  logic               any_ripe;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_obs
    logic [CW-1:0] seen;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) seen <= '0;
      else if (!(uv_flag[g] && rail_en[g] && mon_en)) seen <= '0;
      else if (seen != FULL) seen <= seen + 1'b1;
    end
    assign ripe[g] = (seen == FULL);
  end
  assign any_ripe = |ripe;

  always @(posedge clk) begin
    if (!por_n) AST_RESET_QUIET: assert (!fault && !therm_off); // R1
  end

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fault) |-> $past(any_ripe || ot_warn || ot_shdn || therm_off)); // R2

  AST_WARN_RAISES: assert property (@(posedge clk) disable iff (!por_n)
    (ot_warn && !shdn_req) |=> fault); // R6

  AST_THERM_SETS: assert property (@(posedge clk) disable iff (!por_n)
    ot_shdn |=> therm_off); // R7

  AST_THERM_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    therm_off |=> therm_off); // R7

  AST_SHDN_SILENCES: assert property (@(posedge clk) disable iff (!por_n)
    shdn_req |=> !fault); // R8

  AST_THERM_ONLY_HOT: assert property (@(posedge clk) disable iff (!por_n)
    $rose(therm_off) |-> $past(ot_shdn)); // R9
endmodule

bind uv_fault_monitor ufm_checker #(.N_RAILS(N_RAILS), .DLY_CYC(DLY_CYC)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .uv_flag   (uv_flag),
  .rail_en   (rail_en),
  .mon_en    (mon_en),
  .shdn_req  (shdn_req),
  .ot_warn   (ot_warn),
  .ot_shdn   (ot_shdn),
  .fault     (fault),
  .therm_off (therm_off)
);

// File: tb/tb_uv_fault_monitor.sv
`timescale 1ns/1ps
module tb_uv_fault_monitor;
  localparam int N = 3;
  localparam int D = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [N-1:0] uv_flag = '0;
  logic [N-1:0] rail_en = '1;
  logic mon_en = 1'b1;
  logic shdn_req = 1'b0;
  logic ot_warn = 1'b0;
  logic ot_shdn = 1'b0;
  logic fault, therm_off;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uv_fault_monitor #(.N_RAILS(N), .DLY_CYC(D)) dut (
    .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .rail_en(rail_en),
    .mon_en(mon_en), .shdn_req(shdn_req), .ot_warn(ot_warn),
    .ot_shdn(ot_shdn), .fault(fault), .therm_off(therm_off)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    uv_flag = '0; rail_en = '1; mon_en = 1'b1;
    shdn_req = 1'b0; ot_warn = 1'b0; ot_shdn = 1'b0;
    step(3);
  endtask

  // Sweep one run of length len on rail r with the given enables.
  task automatic run_one(input int r, input bit en, input bit mon, input int len);
    string req;
    logic exp_end, exp_early;
    req = !en ? "R3" : (!mon ? "R4" : "R2");
    exp_end   = en && mon && (len >= D);
    exp_early = en && mon && (len - 1 >= D);
    rail_en[r] = en; mon_en = mon; uv_flag[r] = 1'b1;
    step(len);
    chk(req, fault, exp_early);
    uv_flag[r] = 1'b0;
    step(1);
    chk(req, fault, exp_end);
    step(1);
    chk("R5", fault, 1'b0);
    chk("R9", therm_off, 1'b0);
    idle();
  endtask

  initial begin
    step(3);
    chk("R1", fault, 1'b0);
    chk("R1", therm_off, 1'b0);
    por_n = 1'b1;
    idle();

    // R2, R3, R4, R5, R9: exhaustive sweep
    for (int r = 0; r < N; r++)
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 2; m++)
          for (int len = 1; len <= D + 2; len++)
            run_one(r, e[0], m[0], len);

    // R2: broken run does not accumulate
    uv_flag[0] = 1'b1; step(D - 1);
    uv_flag[0] = 1'b0; step(1);
    uv_flag[0] = 1'b1; step(D - 1);
    uv_flag[0] = 1'b0; step(2);
    chk("R2", fault, 1'b0);
    idle();

    // R10: hand-off between rails does not accumulate
    uv_flag[0] = 1'b1; step(D - 1);
    uv_flag = 3'b010;  step(D - 1);
    uv_flag = '0;      step(2);
    chk("R10", fault, 1'b0);
    idle();

    // R10: two rails reported, dropping one keeps fault
    uv_flag = 3'b101; step(D + 1);
    chk("R10", fault, 1'b1);
    uv_flag = 3'b100; step(3);
    chk("R10", fault, 1'b1);
    uv_flag = '0; step(2);
    chk("R10", fault, 1'b0);
    idle();

    // R6: warning level
    ot_warn = 1'b1; step(1);
    chk("R6", fault, 1'b1);
    chk("R6", therm_off, 1'b0);
    ot_warn = 1'b0; step(1);
    chk("R6", fault, 1'b0);
    idle();

    // R8: shutdown request masks undervoltage and warning
    uv_flag[2] = 1'b1; step(D + 1);
    chk("R8", fault, 1'b1);
    shdn_req = 1'b1; ot_warn = 1'b1; step(1);
    chk("R8", fault, 1'b0);
    step(2);
    chk("R8", fault, 1'b0);
    shdn_req = 1'b0; step(1);
    chk("R8", fault, 1'b1);
    idle();

    // R7: shutdown latch
    ot_shdn = 1'b1; step(1);
    chk("R7", therm_off, 1'b1);
    chk("R7", fault, 1'b1);
    ot_shdn = 1'b0; step(5);
    chk("R7", therm_off, 1'b1);
    chk("R7", fault, 1'b1);
    shdn_req = 1'b1; mon_en = 1'b0; step(2);
    chk("R8", fault, 1'b0);
    chk("R7", therm_off, 1'b1);
    shdn_req = 1'b0; step(1);
    chk("R7", therm_off, 1'b1);
    chk("R7", fault, 1'b1);

    // R1: bias POR clears everything
    por_n = 1'b0; step(2);
    chk("R1", therm_off, 1'b0);
    chk("R1", fault, 1'b0);
    por_n = 1'b1; idle();
    chk("R7", therm_off, 1'b0);
    chk("R1", fault, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule